// File: doc/BRIEF.md
# Wrapping Burst Target Responder

This block sits on the target side of a simple parallel external bus and stands in for a small memory. A bus master opens a transfer with a one-cycle start pulse. On that pulse it gives the start address, a direction flag, a two-bit size code and an active-low burst flag. The responder records these values and walks through the beats of the transfer. Each beat is served from an internal byte-lane RAM whose word width matches the port width. The responder raises a one-cycle acknowledge for every beat and drives read data during that cycle, or stores write data on the clock edge that ends it.

A line-size burst (sixteen bytes) may begin at any offset inside a sixteen-byte line. Its beat addresses then advance by the port width and wrap back to the start of the same line. They never carry into the next line. A fixed number of wait cycles, from zero to seven, comes before every acknowledge. The master picks this count on the start cycle. Single transfers narrower than the port write only the byte lanes they address.

Top module: `wbt_responder`

## Requirements
- R1: The size code means 00 = 4 bytes, 01 = 1 byte, 10 = 2 bytes, 11 = 16 bytes. A write narrower than the port updates only the lanes it covers: byte lane k carries the byte at offset k inside the port word, and that offset comes from the low address bits. The lane group starts at that offset rounded down to the transfer size. Other bytes of the word keep their values.
- R2: With the burst flag low and a transfer size larger than the port, the transfer has size/port-width beats (4 for a line on the default 4-byte port). Every other transfer gets exactly one acknowledge. After the last acknowledge the responder is idle and acknowledges nothing more.
- R3: In a line burst, beat i uses address line_base + ((start_offset + i*port_width) mod 16), where line_base is the start address with its low four bits cleared.
- R4: With the direction flag high, rdata equals the stored port word at the beat address during each acknowledge cycle. With it low, wdata is written into the addressed word on the edge that ends each acknowledge cycle.
- R5: Address, direction, size, burst flag and wait count are taken only on the edge where start is seen while idle. Later changes to those inputs do not affect the transfer.
- R6: Every beat is preceded by exactly W cycles with ack low, where W is the captured wait count (0 to 7). The ack itself lasts one cycle.
- R7: A start pulse that arrives while a transfer is in progress is ignored and does not open a new transfer.
- R8: rdata is zero in every cycle that is not an acknowledge cycle of a read.
- R9: After reset, ack is low, the responder is idle, and every RAM byte reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_start | input | 1 | One-cycle pulse that opens a transfer |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| size_code | input | 2 | Transfer size code (see R1) |
| burst_n | input | 1 | Low marks a burst transfer |
| addr | input | ADDR_W | Byte start address |
| wait_cfg | input | WAIT_W | Wait cycles before each beat |
| wdata | input | 8*PORT_BYTES | Write data for the current beat |
| ack | output | 1 | One-cycle beat acknowledge |
| rdata | output | 8*PORT_BYTES | Read data, valid while ack is high on a read |

## Verification
The checker assumes the master gives start as a single-cycle pulse and keeps wdata steady for the whole acknowledge cycle of a write beat. It also assumes the address and size inputs matter only on the start cycle. It keeps its own record of each accepted transfer, so start pulses that arrive mid-transfer fall outside it. The bench drives start for exactly one cycle. It changes wdata only at the start of a beat. Right after each start it scrambles the other request inputs, and it sends extra start pulses only while a transfer is still in flight.

// File: rtl/wbt_pkg.sv
// Package: shared encodings and decode helpers for the burst responder.
// Assumes a line of 16 bytes and a power-of-two port width of 2..16 bytes.
package wbt_pkg;

    localparam int LINE_BYTES = 16;
    localparam int LINE_W     = 4;

    typedef enum logic [1:0] {
        SZ_WORD = 2'b00,
        SZ_BYTE = 2'b01,
        SZ_HALF = 2'b10,
        SZ_LINE = 2'b11
    } size_code_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BEAT = 1'b1
    } seq_state_e;

    // Number of bytes moved by a whole transfer of the given size code.
    function automatic int unsigned size_bytes(input logic [1:0] code);
        case (code)
            SZ_BYTE: return 1;
            SZ_HALF: return 2;
            SZ_LINE: return LINE_BYTES;
            default: return 4;
        endcase
    endfunction

    // Beat count: bursts wider than the port split into port-width beats.
    function automatic int unsigned beats_for(input logic [1:0] code,
                                              input logic burst_low,
                                              input int unsigned port_bytes);
        int unsigned nb;
        nb = size_bytes(code);
        if (!burst_low && nb > port_bytes) return nb / port_bytes;
        return 1;
    endfunction

endpackage

// File: rtl/wbt_beat_addr.sv
// Beat address generator.
// Computes the byte address of a beat from the captured start address and
// the beat index. Line bursts wrap inside their 16-byte line; other multi-beat
// transfers step linearly. Assumes ADDR_W > LINE_W.
module wbt_beat_addr
    import wbt_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int PORT_BYTES = 4,
    parameter int BEAT_W     = 5
) (
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              wrap_en,
    input  logic [BEAT_W-1:0] beat_idx,
    output logic [ADDR_W-1:0] beat_addr
);

    logic [ADDR_W-1:0] step;
    logic [LINE_W-1:0] line_off;

    // Byte distance of this beat from the start address.
    always_comb begin
        step     = ADDR_W'(beat_idx) * ADDR_W'(PORT_BYTES);
        line_off = start_addr[LINE_W-1:0] + step[LINE_W-1:0];
    end

    // Pick wrapped or linear address.
    always_comb begin
        if (wrap_en) beat_addr = {start_addr[ADDR_W-1:LINE_W], line_off};
        else         beat_addr = start_addr + step;
    end

endmodule

// File: rtl/wbt_lane_mask.sv
// Byte-lane enable generator.
// Transfers at least as wide as the port enable every lane; narrower ones
// enable a group of size-many lanes aligned to the transfer size.
// Assumes PORT_BYTES is a power of two and at least 2.
module wbt_lane_mask
    import wbt_pkg::*;
#(
    parameter int PORT_BYTES = 4,
    parameter int OFF_W      = 2
) (
    input  logic [1:0]            size_code,
    input  logic [OFF_W-1:0]      lane_off,
    output logic [PORT_BYTES-1:0] lane_en
);

    int unsigned      nb;
    logic [OFF_W-1:0] base;

    // Decode the transfer width into a lane group.
    always_comb begin
        nb   = size_bytes(size_code);
        base = lane_off & ~OFF_W'(nb - 1);
        if (nb >= PORT_BYTES) lane_en = '1;
        else                  lane_en = PORT_BYTES'((1 << nb) - 1) << base;
    end

endmodule

// File: rtl/wbt_store.sv
// Byte-lane RAM.
// One small array per byte lane, cleared by reset, written on enabled lanes,
// read asynchronously at the same word index.
module wbt_store #(
    parameter int PORT_BYTES = 4,
    parameter int IDX_W      = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [PORT_BYTES-1:0]   lane_en,
    input  logic [IDX_W-1:0]        idx,
    input  logic [8*PORT_BYTES-1:0] wr_word,
    output logic [8*PORT_BYTES-1:0] rd_word
);

    localparam int DEPTH = 1 << IDX_W;

    for (genvar l = 0; l < PORT_BYTES; l++) begin : g_lane
        logic [7:0] cells [DEPTH];

        // Clear on reset, else store this lane's byte when enabled.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
            end else if (wr_en && lane_en[l]) begin
                cells[idx] <= wr_word[8*l +: 8];
            end
        end

        // Lane read path.
        assign rd_word[8*l +: 8] = cells[idx];
    end

endmodule

// File: rtl/wbt_sequencer.sv
// Transfer sequencer.
// Captures the request on a start pulse seen while idle, then for every beat
// counts the wait cycles and raises ack for one cycle. Returns to idle after
// the final beat. Assumes start is a one-cycle pulse.
module wbt_sequencer
    import wbt_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int PORT_BYTES = 4,
    parameter int WAIT_W     = 3,
    parameter int BEAT_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_start,
    input  logic              rd_nwr,
    input  logic [1:0]        size_code,
    input  logic              burst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WAIT_W-1:0] wait_cfg,
    output logic              ack,
    output logic              rd_q,
    output logic [1:0]        size_q,
    output logic              wrap_q,
    output logic [ADDR_W-1:0] start_q,
    output logic [BEAT_W-1:0] beat_q
);

    seq_state_e        state;
    logic [WAIT_W-1:0] wait_q;
    logic [WAIT_W-1:0] cnt_q;
    logic [BEAT_W-1:0] last_q;

    // A beat is acknowledged once its wait count has run out.
    assign ack = (state == ST_BEAT) && (cnt_q == '0);

    // Request capture, wait counting and beat advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            wait_q  <= '0;
            cnt_q   <= '0;
            last_q  <= '0;
            beat_q  <= '0;
            rd_q    <= 1'b0;
            size_q  <= '0;
            wrap_q  <= 1'b0;
            start_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (xfer_start) begin
                        state   <= ST_BEAT;
                        start_q <= addr;
                        rd_q    <= rd_nwr;
                        size_q  <= size_code;
                        wrap_q  <= !burst_n && (size_code == SZ_LINE);
                        wait_q  <= wait_cfg;
                        cnt_q   <= wait_cfg;
                        beat_q  <= '0;
                        last_q  <= BEAT_W'(beats_for(size_code, burst_n, PORT_BYTES) - 1);
                    end
                end
                ST_BEAT: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (beat_q == last_q) begin
                        state <= ST_IDLE;
                    end else begin
                        beat_q <= beat_q + 1'b1;
                        cnt_q  <= wait_q;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/wbt_responder.sv
// Burst target responder top.
// Joins the sequencer, beat address generator, lane mask and RAM. Read data
// appears only during read acknowledge cycles. Assumes ADDR_W > 4 and a
// power-of-two PORT_BYTES of 2..16.
module wbt_responder
    import wbt_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int PORT_BYTES = 4,
    parameter int WAIT_W     = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    xfer_start,
    input  logic                    rd_nwr,
    input  logic [1:0]              size_code,
    input  logic                    burst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [WAIT_W-1:0]       wait_cfg,
    input  logic [8*PORT_BYTES-1:0] wdata,
    output logic                    ack,
    output logic [8*PORT_BYTES-1:0] rdata
);

    localparam int OFF_W  = $clog2(PORT_BYTES);
    localparam int IDX_W  = ADDR_W - OFF_W;
    localparam int BEAT_W = LINE_W + 1;

    logic                    rd_q;
    logic [1:0]              size_q;
    logic                    wrap_q;
    logic [ADDR_W-1:0]       start_q;
    logic [BEAT_W-1:0]       beat_q;
    logic [ADDR_W-1:0]       beat_addr;
    logic [PORT_BYTES-1:0]   lane_en;
    logic [8*PORT_BYTES-1:0] mem_word;

    wbt_sequencer #(
        .ADDR_W    (ADDR_W),
        .PORT_BYTES(PORT_BYTES),
        .WAIT_W    (WAIT_W),
        .BEAT_W    (BEAT_W)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .xfer_start(xfer_start),
        .rd_nwr    (rd_nwr),
        .size_code (size_code),
        .burst_n   (burst_n),
        .addr      (addr),
        .wait_cfg  (wait_cfg),
        .ack       (ack),
        .rd_q      (rd_q),
        .size_q    (size_q),
        .wrap_q    (wrap_q),
        .start_q   (start_q),
        .beat_q    (beat_q)
    );

    wbt_beat_addr #(
        .ADDR_W    (ADDR_W),
        .PORT_BYTES(PORT_BYTES),
        .BEAT_W    (BEAT_W)
    ) addr_i (
        .start_addr(start_q),
        .wrap_en   (wrap_q),
        .beat_idx  (beat_q),
        .beat_addr (beat_addr)
    );

    wbt_lane_mask #(
        .PORT_BYTES(PORT_BYTES),
        .OFF_W     (OFF_W)
    ) mask_i (
        .size_code(size_q),
        .lane_off (beat_addr[OFF_W-1:0]),
        .lane_en  (lane_en)
    );

    wbt_store #(
        .PORT_BYTES(PORT_BYTES),
        .IDX_W     (IDX_W)
    ) store_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (ack && !rd_q),
        .lane_en(lane_en),
        .idx    (beat_addr[ADDR_W-1:OFF_W]),
        .wr_word(wdata),
        .rd_word(mem_word)
    );

    // Gate read data to read acknowledge cycles.
    always_comb begin
        rdata = (ack && rd_q) ? mem_word : '0;
    end

endmodule

// File: rtl/wbt_responder_chk.sv
// Protocol checker for the burst responder.
// Keeps its own record of accepted transfers (start seen while no transfer
// is open) and checks acknowledge count, spacing and wrap addressing.
module wbt_responder_chk
    import wbt_pkg::*;
#(
    parameter int AW     = 6,
    parameter int PB     = 4,
    parameter int WAIT_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xfer_start,
    input logic [1:0]        size_code,
    input logic              burst_n,
    input logic [AW-1:0]     addr,
    input logic [WAIT_W-1:0] wait_cfg,
    input logic              ack,
    input logic [AW-1:0]     beat_addr
);

    localparam int CW = LINE_W + 1;

    logic              c_busy;
    logic              c_wrap;
    logic [CW-1:0]     c_cnt;
    logic [CW-1:0]     c_beats;
    logic [WAIT_W-1:0] c_wait;
    logic [WAIT_W-1:0] c_gap;
    logic [AW-1:0]     c_addr;

    // Shadow record of the open transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_busy  <= 1'b0;
            c_wrap  <= 1'b0;
            c_cnt   <= '0;
            c_beats <= '0;
            c_wait  <= '0;
            c_gap   <= '0;
            c_addr  <= '0;
        end else if (!c_busy) begin
            if (xfer_start) begin
                c_busy  <= 1'b1;
                c_cnt   <= '0;
                c_beats <= CW'(beats_for(size_code, burst_n, PB));
                c_wait  <= wait_cfg;
                c_gap   <= '0;
                c_addr  <= addr;
                c_wrap  <= !burst_n && (size_code == SZ_LINE);
            end
        end else if (ack) begin
            c_gap <= '0;
            c_cnt <= c_cnt + CW'(1);
            if (c_cnt + CW'(1) == c_beats) c_busy <= 1'b0;
        end else begin
            c_gap <= c_gap + 1'b1;
        end
    end

    // R2
    ack_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> c_busy);

    // R2
    final_beat_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && (c_cnt + CW'(1) == c_beats)) |=> !ack);

    // R6
    ack_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (c_gap == c_wait));

    // R3
    wrap_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && c_wrap) |-> (beat_addr ==
            {c_addr[AW-1:LINE_W], c_addr[LINE_W-1:0] + LINE_W'(c_cnt * CW'(PB))}));

endmodule

bind wbt_responder wbt_responder_chk #(
    .AW    (ADDR_W),
    .PB    (PORT_BYTES),
    .WAIT_W(WAIT_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer_start(xfer_start),
    .size_code (size_code),
    .burst_n   (burst_n),
    .addr      (addr),
    .wait_cfg  (wait_cfg),
    .ack       (ack),
    .beat_addr (beat_addr)
);

// File: tb/wbt_responder_tb_top.sv
// Bench: directed corner cases plus seeded random transfers against a byte model.
module wbt_responder_tb_top;

    localparam int AW = 6;
    localparam int PB = 4;
    localparam int WW = 3;
    localparam int DW = 8 * PB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          xfer_start = 1'b0;
    logic          rd_nwr = 1'b0;
    logic [1:0]    size_code = 2'b00;
    logic          burst_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [WW-1:0] wait_cfg = '0;
    logic [DW-1:0] wdata = '0;
    logic          ack;
    logic [DW-1:0] rdata;

    logic [7:0] model [1 << AW];
    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    wbt_responder #(.ADDR_W(AW), .PORT_BYTES(PB), .WAIT_W(WW)) dut_i (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .rd_nwr(rd_nwr),
        .size_code(size_code), .burst_n(burst_n), .addr(addr),
        .wait_cfg(wait_cfg), .wdata(wdata), .ack(ack), .rdata(rdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int f_bytes(input logic [1:0] sz);
        case (sz)
            2'b01:   return 1;
            2'b10:   return 2;
            2'b11:   return 16;
            default: return 4;
        endcase
    endfunction

    function automatic int f_beats(input logic [1:0] sz, input bit bn);
        if (!bn && f_bytes(sz) > PB) return f_bytes(sz) / PB;
        return 1;
    endfunction

    function automatic logic [AW-1:0] f_addr(input logic [AW-1:0] s, input logic [1:0] sz,
                                             input bit bn, input int i);
        logic [AW-1:0] step;
        step = AW'(i * PB);
        if (!bn && sz == 2'b11) return {s[AW-1:4], 4'(s[3:0] + step[3:0])};
        return s + step;
    endfunction

    function automatic logic [PB-1:0] f_mask(input logic [1:0] sz, input logic [AW-1:0] a);
        int nb;
        int off;
        nb = f_bytes(sz);
        if (nb >= PB) return '1;
        off = (int'(a) % PB) & ~(nb - 1);
        return PB'(((1 << nb) - 1) << off);
    endfunction

    function automatic logic [DW-1:0] f_word(input logic [AW-1:0] a);
        logic [DW-1:0] w;
        int base;
        base = int'(a) & ~(PB - 1);
        for (int l = 0; l < PB; l++) w[8*l +: 8] = model[base + l];
        return w;
    endfunction

    // One complete transfer; inputs are scrambled after start (R5).
    task automatic xfer(input bit rw, input logic [AW-1:0] a, input logic [1:0] sz,
                        input bit bn, input int w, input bit poke, input string rq);
        logic [AW-1:0] ba;
        logic [PB-1:0] m;
        @(negedge clk);
        xfer_start = 1'b1; rd_nwr = rw; addr = a; size_code = sz;
        burst_n = bn; wait_cfg = WW'(w);
        @(negedge clk);
        xfer_start = 1'b0; rd_nwr = ~rw; addr = ~a; size_code = ~sz;
        burst_n = ~bn; wait_cfg = ~WW'(w);
        for (int b = 0; b < f_beats(sz, bn); b++) begin
            ba = f_addr(a, sz, bn, b);
            wdata = {$urandom};
            for (int k = 0; k < w; k++) begin
                chk(ack == 1'b0, "R6", "ack during wait", 64'(ack), 64'(0));
                chk(rdata == '0, "R8", "rdata outside ack", 64'(rdata), 64'(0));
                @(negedge clk);
            end
            chk(ack == 1'b1, "R6", "ack after wait", 64'(ack), 64'(1));
            if (rw) begin
                chk(rdata == f_word(ba), rq, "read beat data", 64'(rdata), 64'(f_word(ba)));
            end else begin
                m = f_mask(sz, ba);
                for (int l = 0; l < PB; l++)
                    if (m[l]) model[(int'(ba) & ~(PB - 1)) + l] = wdata[8*l +: 8];
            end
            if (poke && b == 0) begin
                xfer_start = 1'b1; addr = '0; rd_nwr = 1'b1;
            end
            @(negedge clk);
            xfer_start = 1'b0;
        end
        chk(ack == 1'b0, poke ? "R7" : "R2", "ack after last beat", 64'(ack), 64'(0));
        chk(rdata == '0, "R8", "rdata when idle", 64'(rdata), 64'(0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        for (int i = 0; i < (1 << AW); i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state and cleared RAM
        chk(ack == 1'b0, "R9", "ack after reset", 64'(ack), 64'(0));
        chk(rdata == '0, "R9", "rdata after reset", 64'(rdata), 64'(0));
        for (int a = 0; a < (1 << AW); a += 16) xfer(1, AW'(a), 2'b11, 0, 0, 0, "R9");
        // R4: full-word write then read, with waits
        xfer(0, 6'h08, 2'b00, 1, 2, 0, "R4");
        xfer(1, 6'h08, 2'b00, 1, 1, 0, "R4");
        // R1: byte and half writes touch only their lanes
        xfer(0, 6'h09, 2'b01, 1, 0, 0, "R1");
        xfer(0, 6'h0E, 2'b10, 1, 3, 0, "R1");
        xfer(1, 6'h08, 2'b00, 1, 0, 0, "R1");
        // R3: misaligned line bursts wrap inside the line
        xfer(0, 6'h14, 2'b11, 0, 1, 0, "R3");
        xfer(1, 6'h1C, 2'b11, 0, 0, 0, "R3");
        xfer(0, 6'h33, 2'b11, 0, 7, 0, "R3");
        xfer(1, 6'h3B, 2'b11, 0, 2, 0, "R3");
        // R5: inputs scrambled after start must not alter the read-back
        xfer(1, 6'h10, 2'b11, 1, 0, 0, "R5");
        // R2: burst flag with a port-sized transfer is a single beat
        xfer(0, 6'h24, 2'b00, 0, 0, 0, "R2");
        xfer(1, 6'h24, 2'b00, 1, 0, 0, "R2");
        // R7: start pulses during single and burst transfers are ignored
        xfer(1, 6'h20, 2'b00, 1, 0, 1, "R4");
        xfer(1, 6'h2C, 2'b11, 0, 0, 1, "R3");
        // Random mix
        for (int n = 0; n < 300; n++) begin
            xfer(bit'($urandom_range(1, 0)), AW'($urandom), 2'($urandom_range(3, 0)),
                 bit'($urandom_range(1, 0)), int'($urandom_range(7, 0)),
                 ($urandom_range(7, 0) == 0), "R4");
        end
        // Final full read-back of every line
        for (int a = 0; a < (1 << AW); a += 16) xfer(1, AW'(a), 2'b11, 0, 0, 0, "R4");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule